// File: doc/BRIEF.md
# Four-Step Chained Vector Multiply-Accumulate Sequencer

This block runs a packed single-precision multiply-accumulate as four dependent steps over a 16-lane, 32-bit-per-lane vector. One start pulse supplies everything the operation needs: a source register index, the destination vector, a lane mask, a masking enable, a merge/zero selector, a negate flag, a rounding mode and an exception mask. The block selects an aligned group of four consecutive source registers and reads them one per step from an external register file. At each step it sends the running accumulator, the source vector and one broadcast 32-bit multiplier to an external FMA datapath. The multiplier is taken from a different element of a 128-bit memory operand at each step.

The FMA datapath rounds the result of each request, so rounding happens after every step. The block writes the datapath's result back into the accumulator for the enabled lanes. It requests the memory operand only when at least one lane can be updated. It also merges the per-step exception flags, and the earliest step takes priority. When the last step finishes, the block applies merge or zero masking and writes the final vector. If a step raises an exception that is not masked, the block stops at that step, reports it, and writes nothing.

Top module: `fma4_seq`

## Requirements
- R1: Step j (j = 0..3, in that order) reads source register address {src_idx[4:2], j}: the group is four consecutive registers that start on a multiple of four.
- R2: The multiplier `fma_mult` for step j is bits [32j+31:32j] of the memory operand, broadcast to all lanes.
- R3: Each step is a separate FMA request that carries `rnd_mode`. The accumulator of step 0 is `dest_in`, and the accumulator of step j>0 equals the response of step j-1 on enabled lanes and `dest_in` on the other lanes.
- R4: With `negate`=1 every request has `fma_neg`=1 and each step computes acc − src·m. With `negate`=0 it has `fma_neg`=0 and each step computes acc + src·m.
- R5: A lane is enabled when `use_mask`=0 or its `lane_mask` bit is 1. `fma_lane_en` equals exactly the set of enabled lanes.
- R6: In the final vector, enabled lanes hold the accumulated result. A disabled lane holds its `dest_in` value when `zero_mode`=0, and holds zero when `zero_mode`=1.
- R7: Exactly one `mem_req` pulse is issued per operation when `use_mask`=0 or `lane_mask` is nonzero. Otherwise no pulse is issued.
- R8: With `use_mask`=1 and an all-zero `lane_mask`, no load and no FMA request occur. `done` and `dest_we` rise in the cycle after the start edge, and the result is all zeros (`zero_mode`=1) or `dest_in` (`zero_mode`=0).
- R9: For a full run, `busy` is high from the cycle after start until `done`. `done` and `dest_we` are single-cycle pulses, and `busy` is low while `done` is high.
- R10: Flag bits are: bit0 invalid, bit1 denormal, bit2 overflow, bit3 underflow, bit4 precision. On `done`, `flags_out` is the OR of the step flags taken from enabled lanes only. Flags that disabled lanes report are ignored.
- R11: A step whose flags include a bit that is clear in `exc_mask` (bit set = exception masked) is a fault. The block pulses `fault`, reports the first such step in `fault_step` and that step's flags in `flags_out`, issues no further FMA requests, and never asserts `dest_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation (sampled when idle) |
| src_idx | input | 5 | Encoded source register index |
| dest_in | input | 512 | Initial destination / accumulator vector |
| lane_mask | input | 16 | Per-lane write mask |
| use_mask | input | 1 | 1 = lane_mask applies, 0 = all lanes enabled |
| zero_mode | input | 1 | 1 = zero disabled lanes, 0 = keep them |
| negate | input | 1 | 1 = subtract products |
| rnd_mode | input | 2 | Rounding mode passed to each step |
| exc_mask | input | 5 | Masked exception bits |
| mem_req | output | 1 | Memory operand load request pulse |
| mem_valid | input | 1 | Memory operand valid |
| mem_data | input | 128 | Four 32-bit multiplier elements |
| rf_rd_en | output | 1 | Register file read strobe |
| rf_rd_addr | output | 5 | Register file read address |
| rf_rd_data | input | 512 | Register file data, one cycle after the strobe |
| fma_req_valid | output | 1 | FMA step request pulse |
| fma_lane_en | output | 16 | Lanes taking part in this step |
| fma_acc | output | 512 | Addend vector |
| fma_src | output | 512 | Source vector |
| fma_mult | output | 32 | Broadcast multiplier |
| fma_neg | output | 1 | Subtract product |
| fma_rnd | output | 2 | Rounding mode for this step |
| fma_rsp_valid | input | 1 | FMA result valid |
| fma_rsp_data | input | 512 | FMA result vector |
| fma_rsp_flags | input | 80 | Five flag bits per lane |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final vector valid (pulse) |
| dest_we | output | 1 | Destination write enable (pulse) |
| dest_out | output | 512 | Final masked vector |
| flags_out | output | 5 | Merged or faulting flags |
| fault | output | 1 | Unmasked exception stop (pulse) |
| fault_step | output | 2 | Step that faulted |

## Verification
The bench builds the block with its default parameters: 16 lanes of 32 bits, four steps and a 5-bit register index. With these values a source index of 31 exercises the top aligned group (28 to 31), and the full 16-bit mask reaches alternating and sparse lane patterns. The models of the register file, memory and FMA datapath use wrapping integer arithmetic and fixed delays. This lets the accumulator chain, the choice of the negated form and the final masking be predicted exactly. The FMA model deliberately returns garbage data and all-ones flags on disabled lanes, so the bench can confirm that the block ignores those lanes.

// File: rtl/fma4_pkg.sv
package fma4_pkg;
  localparam int FLAG_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_READ,
    ST_ISSUE,
    ST_WAIT
  } seq_state_t;
endpackage

// File: rtl/fma4_addr_gen.sv
module fma4_addr_gen #(
  parameter int STEPS  = 4,
  parameter int EW     = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0]          src_idx,
  input  logic [$clog2(STEPS)-1:0]   rd_step,
  input  logic [$clog2(STEPS)-1:0]   mult_step,
  input  logic [STEPS*EW-1:0]        mem_op,
  output logic [REG_AW-1:0]          rd_addr,
  output logic [EW-1:0]              mult
);
  localparam int SW = $clog2(STEPS);

  // aligned group base with the step number in the low bits
  assign rd_addr = {src_idx[REG_AW-1:SW], rd_step};
  assign mult    = mem_op[mult_step*EW +: EW];
endmodule

// File: rtl/fma4_lane_ctrl.sv
module fma4_lane_ctrl #(
  parameter int LANES = 16,
  parameter int EW    = 32
) (
  input  logic [LANES-1:0]    lane_mask,
  input  logic                use_mask,
  input  logic                zero_mode,
  input  logic [LANES*EW-1:0] acc,
  input  logic [LANES*EW-1:0] rsp,
  input  logic [LANES*EW-1:0] orig,
  output logic [LANES-1:0]    lane_en,
  output logic [LANES*EW-1:0] acc_next,
  output logic [LANES*EW-1:0] final_vec
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_en[l] = ~use_mask | lane_mask[l];
    assign acc_next[l*EW +: EW]  = lane_en[l] ? rsp[l*EW +: EW] : acc[l*EW +: EW];
    assign final_vec[l*EW +: EW] = lane_en[l] ? rsp[l*EW +: EW] :
                                   (zero_mode ? '0 : orig[l*EW +: EW]);
  end
endmodule

// File: rtl/fma4_exc_merge.sv
module fma4_exc_merge import fma4_pkg::*; #(
  parameter int LANES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    capture,
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*FLAG_W-1:0] rsp_flags,
  input  logic [FLAG_W-1:0]       exc_mask,
  output logic [FLAG_W-1:0]       step_flags,
  output logic                    step_fault,
  output logic [FLAG_W-1:0]       sticky_flags
);
  always_comb begin
    step_flags = '0;
    for (int l = 0; l < LANES; l++) begin
      if (lane_en[l]) step_flags = step_flags | rsp_flags[l*FLAG_W +: FLAG_W];
    end
  end

  assign step_fault = |(step_flags & ~exc_mask);

  always_ff @(posedge clk) begin
    if (rst || clr)                 sticky_flags <= '0;
    else if (capture && !step_fault) sticky_flags <= sticky_flags | step_flags;
  end

  AST_STICKY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> sticky_flags == '0); // R10
endmodule

// File: rtl/fma4_seq.sv
module fma4_seq import fma4_pkg::*; #(
  parameter int LANES  = 16,
  parameter int EW     = 32,
  parameter int STEPS  = 4,
  parameter int REG_AW = 5,
  parameter int RM_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [REG_AW-1:0]           src_idx,
  input  logic [LANES*EW-1:0]         dest_in,
  input  logic [LANES-1:0]            lane_mask,
  input  logic                        use_mask,
  input  logic                        zero_mode,
  input  logic                        negate,
  input  logic [RM_W-1:0]             rnd_mode,
  input  logic [FLAG_W-1:0]           exc_mask,
  output logic                        mem_req,
  input  logic                        mem_valid,
  input  logic [STEPS*EW-1:0]         mem_data,
  output logic                        rf_rd_en,
  output logic [REG_AW-1:0]           rf_rd_addr,
  input  logic [LANES*EW-1:0]         rf_rd_data,
  output logic                        fma_req_valid,
  output logic [LANES-1:0]            fma_lane_en,
  output logic [LANES*EW-1:0]         fma_acc,
  output logic [LANES*EW-1:0]         fma_src,
  output logic [EW-1:0]               fma_mult,
  output logic                        fma_neg,
  output logic [RM_W-1:0]             fma_rnd,
  input  logic                        fma_rsp_valid,
  input  logic [LANES*EW-1:0]         fma_rsp_data,
  input  logic [LANES*FLAG_W-1:0]     fma_rsp_flags,
  output logic                        busy,
  output logic                        done,
  output logic                        dest_we,
  output logic [LANES*EW-1:0]         dest_out,
  output logic [FLAG_W-1:0]           flags_out,
  output logic                        fault,
  output logic [$clog2(STEPS)-1:0]    fault_step
);
  localparam int SW = $clog2(STEPS);
  localparam int VW = LANES * EW;
  localparam int MW = STEPS * EW;
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  seq_state_t          state;
  logic [SW-1:0]       step_q;
  logic [REG_AW-1:0]   src_q;
  logic [LANES-1:0]    mask_q;
  logic                use_mask_q, zero_q, neg_q;
  logic [RM_W-1:0]     rnd_q;
  logic [FLAG_W-1:0]   excm_q;
  logic [VW-1:0]       orig_q, acc_q;
  logic [MW-1:0]       mem_q;

  logic [SW-1:0]       addr_step;
  logic [REG_AW-1:0]   next_addr;
  logic [EW-1:0]       cur_mult;
  logic [LANES-1:0]    lane_en;
  logic [VW-1:0]       acc_next, final_vec;
  logic [FLAG_W-1:0]   step_flags, sticky_flags;
  logic                step_fault;
  logic                take_start, skip_now, rsp_take;

  assign take_start = start && (state == ST_IDLE);
  assign skip_now   = use_mask && (lane_mask == '0);
  assign rsp_take   = fma_rsp_valid && (state == ST_WAIT);
  assign addr_step  = (state == ST_LOAD) ? '0 : step_q + 1'b1;

  fma4_addr_gen #(.STEPS(STEPS), .EW(EW), .REG_AW(REG_AW)) u_addr (
    .src_idx  (src_q),
    .rd_step  (addr_step),
    .mult_step(step_q),
    .mem_op   (mem_q),
    .rd_addr  (next_addr),
    .mult     (cur_mult)
  );

  fma4_lane_ctrl #(.LANES(LANES), .EW(EW)) u_lane (
    .lane_mask(mask_q),
    .use_mask (use_mask_q),
    .zero_mode(zero_q),
    .acc      (acc_q),
    .rsp      (fma_rsp_data),
    .orig     (orig_q),
    .lane_en  (lane_en),
    .acc_next (acc_next),
    .final_vec(final_vec)
  );

  fma4_exc_merge #(.LANES(LANES)) u_exc (
    .clk         (clk),
    .rst         (rst),
    .clr         (take_start),
    .capture     (rsp_take),
    .lane_en     (lane_en),
    .rsp_flags   (fma_rsp_flags),
    .exc_mask    (excm_q),
    .step_flags  (step_flags),
    .step_fault  (step_fault),
    .sticky_flags(sticky_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      step_q        <= '0;
      src_q         <= '0;
      mask_q        <= '0;
      use_mask_q    <= 1'b0;
      zero_q        <= 1'b0;
      neg_q         <= 1'b0;
      rnd_q         <= '0;
      excm_q        <= '0;
      orig_q        <= '0;
      acc_q         <= '0;
      mem_q         <= '0;
      mem_req       <= 1'b0;
      rf_rd_en      <= 1'b0;
      rf_rd_addr    <= '0;
      fma_req_valid <= 1'b0;
      fma_lane_en   <= '0;
      fma_acc       <= '0;
      fma_src       <= '0;
      fma_mult      <= '0;
      fma_neg       <= 1'b0;
      fma_rnd       <= '0;
      busy          <= 1'b0;
      done          <= 1'b0;
      dest_we       <= 1'b0;
      dest_out      <= '0;
      flags_out     <= '0;
      fault         <= 1'b0;
      fault_step    <= '0;
    end else begin
      mem_req       <= 1'b0;
      rf_rd_en      <= 1'b0;
      fma_req_valid <= 1'b0;
      done          <= 1'b0;
      dest_we       <= 1'b0;
      fault         <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take_start) begin
            src_q      <= src_idx;
            mask_q     <= lane_mask;
            use_mask_q <= use_mask;
            zero_q     <= zero_mode;
            neg_q      <= negate;
            rnd_q      <= rnd_mode;
            excm_q     <= exc_mask;
            orig_q     <= dest_in;
            acc_q      <= dest_in;
            step_q     <= '0;
            if (skip_now) begin
              done      <= 1'b1;
              dest_we   <= 1'b1;
              dest_out  <= zero_mode ? '0 : dest_in;
              flags_out <= '0;
            end else begin
              mem_req <= 1'b1;
              busy    <= 1'b1;
              state   <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (mem_valid) begin
            mem_q      <= mem_data;
            rf_rd_en   <= 1'b1;
            rf_rd_addr <= next_addr;
            state      <= ST_READ;
          end
        end
        ST_READ: state <= ST_ISSUE;
        ST_ISSUE: begin
          fma_req_valid <= 1'b1;
          fma_lane_en   <= lane_en;
          fma_acc       <= acc_q;
          fma_src       <= rf_rd_data;
          fma_mult      <= cur_mult;
          fma_neg       <= neg_q;
          fma_rnd       <= rnd_q;
          state         <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fma_rsp_valid) begin
            if (step_fault) begin
              fault      <= 1'b1;
              fault_step <= step_q;
              flags_out  <= step_flags;
              busy       <= 1'b0;
              state      <= ST_IDLE;
            end else if (step_q == LAST) begin
              acc_q     <= acc_next;
              dest_out  <= final_vec;
              flags_out <= sticky_flags | step_flags;
              done      <= 1'b1;
              dest_we   <= 1'b1;
              busy      <= 1'b0;
              state     <= ST_IDLE;
            end else begin
              acc_q      <= acc_next;
              step_q     <= step_q + 1'b1;
              rf_rd_en   <= 1'b1;
              rf_rd_addr <= next_addr;
              state      <= ST_READ;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RD_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
    rf_rd_en |-> rf_rd_addr[REG_AW-1:SW] == src_q[REG_AW-1:SW]); // R1
  AST_RSP_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst)
    fma_rsp_valid |-> state == ST_WAIT); // R3
  AST_REQ_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
    fma_req_valid |-> fma_lane_en != '0); // R5
  AST_MEM_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R7
  AST_MEM_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (!use_mask_q || mask_q != '0)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && dest_we); // R9
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    fault |-> !dest_we && !done); // R11
endmodule

// File: tb/fma4_seq_tb.sv
`timescale 1ns/1ps
module fma4_seq_tb;
  localparam int LANES = 16;
  localparam int EW    = 32;
  localparam int STEPS = 4;
  localparam int VW    = LANES * EW;
  localparam int FW    = 5;
  localparam int LAT   = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, start, use_mask, zero_mode, negate;
  logic [4:0] src_idx;
  logic [VW-1:0] dest_in;
  logic [LANES-1:0] lane_mask;
  logic [1:0] rnd_mode;
  logic [FW-1:0] exc_mask;
  logic mem_req, mem_valid;
  logic [STEPS*EW-1:0] mem_data;
  logic rf_rd_en;
  logic [4:0] rf_rd_addr;
  logic [VW-1:0] rf_rd_data;
  logic fma_req_valid, fma_neg, fma_rsp_valid;
  logic [LANES-1:0] fma_lane_en;
  logic [VW-1:0] fma_acc, fma_src, fma_rsp_data;
  logic [EW-1:0] fma_mult;
  logic [1:0] fma_rnd;
  logic [LANES*FW-1:0] fma_rsp_flags;
  logic busy, done, dest_we, fault;
  logic [VW-1:0] dest_out;
  logic [FW-1:0] flags_out;
  logic [1:0] fault_step;

  fma4_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .src_idx(src_idx), .dest_in(dest_in),
    .lane_mask(lane_mask), .use_mask(use_mask), .zero_mode(zero_mode),
    .negate(negate), .rnd_mode(rnd_mode), .exc_mask(exc_mask),
    .mem_req(mem_req), .mem_valid(mem_valid), .mem_data(mem_data),
    .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .fma_req_valid(fma_req_valid), .fma_lane_en(fma_lane_en), .fma_acc(fma_acc),
    .fma_src(fma_src), .fma_mult(fma_mult), .fma_neg(fma_neg), .fma_rnd(fma_rnd),
    .fma_rsp_valid(fma_rsp_valid), .fma_rsp_data(fma_rsp_data),
    .fma_rsp_flags(fma_rsp_flags), .busy(busy), .done(done), .dest_we(dest_we),
    .dest_out(dest_out), .flags_out(flags_out), .fault(fault), .fault_step(fault_step)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] regvec(input logic [4:0] r);
    logic [VW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*EW +: EW] = 32'(int'(r) * 1000 + l * 7 + 3);
    return v;
  endfunction

  // register file model, one-cycle read
  always @(posedge clk) if (rf_rd_en) rf_rd_data <= regvec(rf_rd_addr);

  // memory model
  logic [STEPS*EW-1:0] tb_mem;
  int mdly;
  always @(posedge clk) begin
    if (rst) begin
      mem_valid <= 1'b0;
      mdly <= 0;
    end else begin
      mem_valid <= 1'b0;
      if (mem_req) mdly <= 2;
      else if (mdly != 0) begin
        mdly <= mdly - 1;
        if (mdly == 1) mem_valid <= 1'b1;
      end
    end
  end
  assign mem_data = tb_mem;

  // FMA model with logging; disabled lanes return garbage and all-ones flags
  logic [FW-1:0] inj [STEPS];
  logic [VW-1:0] a_log [8];
  logic [EW-1:0] c_log [8];
  logic [LANES-1:0] en_log [8];
  logic neg_log [8];
  logic [1:0] rnd_log [8];
  logic [4:0] addr_log [8];
  int req_cnt, rd_cnt, mem_cnt, we_cnt;
  logic pv [LAT];
  logic [VW-1:0] pd [LAT];
  logic [LANES*FW-1:0] pf [LAT];

  always @(posedge clk) begin
    if (rf_rd_en) begin
      if (rd_cnt < 8) addr_log[rd_cnt] <= rf_rd_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_req) mem_cnt <= mem_cnt + 1;
    if (dest_we) we_cnt <= we_cnt + 1;
    for (int k = LAT - 1; k > 0; k--) begin
      pv[k] <= pv[k-1];
      pd[k] <= pd[k-1];
      pf[k] <= pf[k-1];
    end
    pv[0] <= rst ? 1'b0 : fma_req_valid;
    if (fma_req_valid) begin
      logic [VW-1:0] r;
      logic [LANES*FW-1:0] f;
      for (int l = 0; l < LANES; l++) begin
        logic [EW-1:0] p;
        p = fma_src[l*EW +: EW] * fma_mult;
        if (fma_lane_en[l]) begin
          r[l*EW +: EW] = fma_neg ? fma_acc[l*EW +: EW] - p : fma_acc[l*EW +: EW] + p;
          f[l*FW +: FW] = (req_cnt < STEPS) ? inj[req_cnt] : '0;
        end else begin
          r[l*EW +: EW] = 32'hDEAD_BEEF;
          f[l*FW +: FW] = '1;
        end
      end
      pd[0] <= r;
      pf[0] <= f;
      if (req_cnt < 8) begin
        a_log[req_cnt]   <= fma_acc;
        c_log[req_cnt]   <= fma_mult;
        en_log[req_cnt]  <= fma_lane_en;
        neg_log[req_cnt] <= fma_neg;
        rnd_log[req_cnt] <= fma_rnd;
      end
      req_cnt <= req_cnt + 1;
    end
  end
  assign fma_rsp_valid = pv[LAT-1];
  assign fma_rsp_data  = pd[LAT-1];
  assign fma_rsp_flags = pf[LAT-1];

  task automatic run_op(input string tag, input logic [4:0] src, input logic [15:0] mask,
                        input bit um, input bit zm, input bit ng, input logic [1:0] rm,
                        input logic [FW-1:0] em, input logic [127:0] mem,
                        input logic [31:0] seed, input logic [19:0] injv);
    logic [LANES-1:0] en;
    logic [VW-1:0] dst, acc, expv;
    logic [FW-1:0] expf;
    logic [4:0] base;
    bit skip;
    int fstep, nsteps, cyc;
    en   = um ? mask : '1;
    skip = um && (mask == '0);
    for (int l = 0; l < LANES; l++) dst[l*EW +: EW] = seed + 32'(l * 13);
    for (int j = 0; j < STEPS; j++) inj[j] = injv[j*FW +: FW];
    fstep = -1;
    for (int j = 0; j < STEPS; j++)
      if (!skip && fstep < 0 && (inj[j] & ~em) != '0) fstep = j;
    nsteps = skip ? 0 : (fstep >= 0 ? fstep + 1 : STEPS);
    expf = '0;
    if (fstep >= 0) expf = inj[fstep];
    else if (!skip) for (int j = 0; j < STEPS; j++) expf |= inj[j];
    base = {src[4:2], 2'b00};

    @(negedge clk);
    req_cnt = 0; rd_cnt = 0; mem_cnt = 0; we_cnt = 0;
    tb_mem = mem; src_idx = src; lane_mask = mask; use_mask = um; zero_mode = zm;
    negate = ng; rnd_mode = rm; exc_mask = em; dest_in = dst; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (!skip) chk(busy === 1'b1, "R9", {tag, " busy after start"}, VW'(busy), VW'(1));
    while (!(done || fault) && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (skip) chk(cyc == 1, "R8", {tag, " skip latency"}, VW'(cyc), VW'(1));
    chk(mem_cnt == (skip ? 0 : 1), "R7", {tag, " load count"}, VW'(mem_cnt), VW'(skip ? 0 : 1));
    chk(req_cnt == nsteps, "R3", {tag, " request count"}, VW'(req_cnt), VW'(nsteps));
    acc = dst;
    for (int j = 0; j < nsteps; j++) begin
      logic [VW-1:0] rv;
      logic [EW-1:0] m;
      rv = regvec(base + 5'(j));
      m  = mem[j*EW +: EW];
      chk(addr_log[j] == base + 5'(j), "R1", {tag, " read address"}, VW'(addr_log[j]), VW'(base + 5'(j)));
      chk(c_log[j] == m, "R2", {tag, " multiplier"}, VW'(c_log[j]), VW'(m));
      chk(a_log[j] == acc, "R3", {tag, " addend chain"}, a_log[j], acc);
      chk(rnd_log[j] == rm, "R3", {tag, " rounding"}, VW'(rnd_log[j]), VW'(rm));
      chk(neg_log[j] == ng, "R4", {tag, " negate"}, VW'(neg_log[j]), VW'(ng));
      chk(en_log[j] == en, "R5", {tag, " lane enables"}, VW'(en_log[j]), VW'(en));
      for (int l = 0; l < LANES; l++)
        if (en[l]) begin
          logic [EW-1:0] p;
          p = rv[l*EW +: EW] * m;
          acc[l*EW +: EW] = ng ? acc[l*EW +: EW] - p : acc[l*EW +: EW] + p;
        end
    end
    if (fstep >= 0) begin
      chk(fault === 1'b1 && done === 1'b0, "R11", {tag, " fault pulse"}, VW'(fault), VW'(1));
      chk(fault_step == 2'(fstep), "R11", {tag, " fault step"}, VW'(fault_step), VW'(fstep));
      chk(flags_out == expf, "R11", {tag, " fault flags"}, VW'(flags_out), VW'(expf));
      @(negedge clk);
      chk(we_cnt == 0, "R11", {tag, " no write"}, VW'(we_cnt), VW'(0));
    end else begin
      for (int l = 0; l < LANES; l++)
        expv[l*EW +: EW] = en[l] ? acc[l*EW +: EW] : (zm ? '0 : dst[l*EW +: EW]);
      chk(done === 1'b1 && dest_we === 1'b1 && busy === 1'b0, "R9", {tag, " done state"},
          VW'({done, dest_we, busy}), VW'(3'b110));
      chk(dest_out == expv, skip ? "R8" : "R6", {tag, " result"}, dest_out, expv);
      chk(flags_out == expf, "R10", {tag, " flags"}, VW'(flags_out), VW'(expf));
      @(negedge clk);
      chk(done === 1'b0 && dest_we === 1'b0, "R9", {tag, " done one cycle"},
          VW'({done, dest_we}), VW'(0));
    end
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done === 1'b0 && fault === 1'b0 && mem_req === 1'b0
        && fma_req_valid === 1'b0 && dest_we === 1'b0, "R9", "reset outputs",
        VW'({busy, done, fault, mem_req, fma_req_valid, dest_we}), VW'(0));
  endtask

  task automatic t_add_nomask();   // R1 R2 R3 R4 R5
    run_op("add_nomask", 5'd5, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd2, 5'h1F,
           128'h0000_0009_0000_0007_0000_0005_0000_0003, 32'h100, '0);
  endtask

  task automatic t_neg_merge();    // R4 R6 top group
    run_op("neg_merge", 5'd31, 16'hA5C3, 1'b1, 1'b0, 1'b1, 2'd1, 5'h1F,
           128'h0000_0002_0000_0011_FFFF_FFFF_0000_0004, 32'h7000, '0);
  endtask

  task automatic t_zero_partial(); // R6
    run_op("zero_partial", 5'd8, 16'h0F0F, 1'b1, 1'b1, 1'b0, 2'd3, 5'h1F,
           128'h0000_0001_0000_0002_0000_0003_0000_0004, 32'h55, '0);
  endtask

  task automatic t_skip_zero();    // R8
    run_op("skip_zero", 5'd12, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd0, 5'h00,
           128'h1, 32'h9999, 20'hFFFFF);
  endtask

  task automatic t_skip_merge();   // R8
    run_op("skip_merge", 5'd2, 16'h0000, 1'b1, 1'b0, 1'b1, 2'd0, 5'h00,
           128'h2, 32'h4242, 20'hFFFFF);
  endtask

  task automatic t_nomask_zero_bits(); // R5 R7
    run_op("nomask_zero_bits", 5'd19, 16'h0000, 1'b0, 1'b1, 1'b1, 2'd0, 5'h1F,
           128'h0000_0003_0000_0001_0000_0004_0000_0001, 32'h0, '0);
  endtask

  task automatic t_masked_flags(); // R10: precision step1, underflow step3, all masked
    run_op("masked_flags", 5'd22, 16'h8001, 1'b1, 1'b0, 1'b0, 2'd1, 5'h1F,
           128'h0000_0005_0000_0006_0000_0007_0000_0008, 32'h321,
           {5'b01000, 5'b00000, 5'b10000, 5'b00000});
  endtask

  task automatic t_fault_priority(); // R11: overflow unmasked at steps 1 and 2, step 1 wins
    run_op("fault_priority", 5'd14, 16'hFFFF, 1'b1, 1'b0, 1'b0, 2'd2, 5'b11011,
           128'h0000_0001_0000_0001_0000_0001_0000_0001, 32'h10,
           {5'b00000, 5'b00100, 5'b00100, 5'b10000});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; src_idx = '0; dest_in = '0; lane_mask = '0;
    use_mask = 1'b0; zero_mode = 1'b0; negate = 1'b0; rnd_mode = '0; exc_mask = '0;
    tb_mem = '0;
    for (int j = 0; j < STEPS; j++) inj[j] = '0;
    req_cnt = 0; rd_cnt = 0; mem_cnt = 0; we_cnt = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_add_nomask();
    t_neg_merge();
    t_zero_partial();
    t_skip_zero();
    t_skip_merge();
    t_nomask_zero_bits();
    t_masked_flags();
    t_fault_priority();
    t_add_nomask();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule